// File: doc/BRIEF.md
# Raster Timing Generator with Border and Display Window

This block produces the horizontal and vertical timing of a video raster. Two counters step through the clocks of a line and the lines of a field, with lengths set by programmable totals. From the counter values the block derives active-high horizontal and vertical sync, a border region and a display window that sits inside that border. Outputs include a field indicator for interlaced frames, a pixel-clock enable, and pixel and line coordinates that are relative to the window.

Software configures the block through a write-only register port. Every write goes into a shadow copy. The whole shadow set moves to the active set at the field wrap, which is also where vertical sync starts, so a frame never changes timing partway through. The active configuration can enable interlace, doublescan, horizontal pixel doubling, a half-rate pixel clock and blanking. Blanking works by letting the border cover the whole visible area, so the window never shows.

Top module: `raster_timing`

## Requirements
- R1: After reset the counters are at zero and the reset configuration is active: hsync=1, vsync=1, field=0, win_act=0, border_act=0, pix_ce=1.
- R2: The horizontal counter runs from 0 to the horizontal total (register 0, bits 11:0), so a line lasts total+1 pixel steps. hsync is high while the counter is below the horizontal border start (register 1, bits 27:16).
- R3: The vertical counter runs from 0 to the vertical total (register 0, bits 27:16). vsync is high while the line count is below the vertical border start (register 2, bits 27:16).
- R4: border_act is high inside the border rectangle and outside the window. The border rectangle is horizontal start ≤ h < horizontal stop (register 1, bits 11:0) and vertical start ≤ v < vertical stop (register 2, bits 11:0). border_rgb shows the border colour (register 5, bits 23:0).
- R5: win_act is high inside the border where h ≥ window start column (register 3, bits 11:0) and v ≥ the window start line. There, pix_x = h − column start and line_y = v − start line. Outside the window both are 0.
- R6: A register write changes nothing until the next field wrap. At the wrap the whole shadow set becomes active and both counters restart at 0.
- R7: Blank (register 6, bit 3) holds win_act at 0, so border_act covers the entire border rectangle.
- R8: With interlace (register 8, bit 4) set, field toggles at every field wrap. The first field after interlace is enabled is field 1. Field 0 uses the start line in register 4, bits 11:0, and field 1 uses register 4, bits 27:16. With interlace clear, field is 0.
- R9: Doublescan (register 7, bit 1) outputs each line twice: the line count advances only on every second horizontal wrap.
- R10: Pixel doubling (register 6, bit 0) halves pix_x: pix_x = (h − column start) >> 1.
- R11: Register 7, bit 23 set gives pix_ce=1 every clock. Clear gives half rate: after a field wrap pix_ce is 0, then alternates, and the counters advance only in cycles with pix_ce=1.
- R12: Display enable (register 7, bit 0) clear holds win_act at 0. Video enable (register 8, bit 8) clear holds hsync, vsync, border_act and win_act at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index 0..8 |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| border_act | output | 1 | Border colour is shown |
| win_act | output | 1 | Display window is shown |
| field | output | 1 | Current interlace field |
| pix_ce | output | 1 | Pixel step enable |
| pix_x | output | CW | Window-relative pixel column |
| line_y | output | CW | Window-relative line |
| border_rgb | output | CLRW | Active border colour |

## Verification
All outputs are combinational functions of the registered counters and the active configuration. They therefore change in the same cycle as the counter state that produces them, and the bench compares them at every falling edge against a model that steps the counters by the requirements. A write lands in the shadow copy at the next rising edge but has no visible effect until the following field wrap. Each scenario therefore first aligns on a wrap, programs the registers, and then waits for the next rising edge of vsync. The sample taken there is step zero of the new field. The shadow-timing check counts clocks between consecutive vsync rises to show that the field in progress keeps its old length.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int CW       = 12,
  parameter int CLRW     = 24,
  parameter int RST_HTOT = 63,
  parameter int RST_VTOT = 15,
  parameter int RST_HBS  = 8,
  parameter int RST_HBE  = 56,
  parameter int RST_VBS  = 2,
  parameter int RST_VBE  = 14,
  parameter int RST_HWS  = 12,
  parameter int RST_VWS  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [31:0]     wr_data,
  output logic            hsync,
  output logic            vsync,
  output logic            border_act,
  output logic            win_act,
  output logic            field,
  output logic            pix_ce,
  output logic [CW-1:0]   pix_x,
  output logic [CW-1:0]   line_y,
  output logic [CLRW-1:0] border_rgb
);

  typedef struct packed {
    logic [CW-1:0]   htot;
    logic [CW-1:0]   vtot;
    logic [CW-1:0]   hbs;
    logic [CW-1:0]   hbe;
    logic [CW-1:0]   vbs;
    logic [CW-1:0]   vbe;
    logic [CW-1:0]   hws;
    logic [CW-1:0]   vws0;
    logic [CW-1:0]   vws1;
    logic [CLRW-1:0] rgb;
    logic            pixdbl;
    logic            blank;
    logic            disp;
    logic            dscan;
    logic            fast;
    logic            ilace;
    logic            vid;
  } cfg_t;

  localparam cfg_t RST_CFG = '{
    htot: CW'(RST_HTOT), vtot: CW'(RST_VTOT),
    hbs: CW'(RST_HBS), hbe: CW'(RST_HBE),
    vbs: CW'(RST_VBS), vbe: CW'(RST_VBE),
    hws: CW'(RST_HWS), vws0: CW'(RST_VWS), vws1: CW'(RST_VWS),
    rgb: '0, pixdbl: 1'b0, blank: 1'b0, disp: 1'b1, dscan: 1'b0,
    fast: 1'b1, ilace: 1'b0, vid: 1'b1
  };

  cfg_t sh, act;
  logic [CW-1:0] hcnt, vcnt;
  logic rep, ce_q, fld;
  logic unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= RST_CFG;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0: begin sh.htot <= wr_data[CW-1:0]; sh.vtot <= wr_data[16 +: CW]; end
        4'd1: begin sh.hbe  <= wr_data[CW-1:0]; sh.hbs  <= wr_data[16 +: CW]; end
        4'd2: begin sh.vbe  <= wr_data[CW-1:0]; sh.vbs  <= wr_data[16 +: CW]; end
        4'd3: sh.hws <= wr_data[CW-1:0];
        4'd4: begin sh.vws0 <= wr_data[CW-1:0]; sh.vws1 <= wr_data[16 +: CW]; end
        4'd5: sh.rgb <= wr_data[CLRW-1:0];
        4'd6: begin sh.pixdbl <= wr_data[0]; sh.blank <= wr_data[3]; end
        4'd7: begin sh.disp <= wr_data[0]; sh.dscan <= wr_data[1]; sh.fast <= wr_data[23]; end
        4'd8: begin sh.ilace <= wr_data[4]; sh.vid <= wr_data[8]; end
        default: ;
      endcase
    end
  end

  logic h_end, line_adv, wrap;
  assign h_end    = ce_q && (hcnt == act.htot);
  assign line_adv = h_end && (!act.dscan || rep);
  assign wrap     = line_adv && (vcnt == act.vtot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= RST_CFG;
      hcnt <= '0;
      vcnt <= '0;
      rep  <= 1'b0;
      ce_q <= 1'b1;
      fld  <= 1'b0;
    end else if (wrap) begin
      act  <= sh;
      hcnt <= '0;
      vcnt <= '0;
      rep  <= 1'b0;
      ce_q <= sh.fast;
      fld  <= sh.ilace ? ~fld : 1'b0;
    end else begin
      ce_q <= act.fast | ~ce_q;
      if (h_end) begin
        hcnt <= '0;
        rep  <= act.dscan & ~rep;
        if (line_adv) vcnt <= vcnt + 1'b1;
      end else if (ce_q) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  logic [CW-1:0] vws, dx;
  logic in_bh, in_bv, in_wh, in_wv, show;

  assign vws   = fld ? act.vws1 : act.vws0;
  assign in_bh = (hcnt >= act.hbs) && (hcnt < act.hbe);
  assign in_bv = (vcnt >= act.vbs) && (vcnt < act.vbe);
  assign in_wh = (hcnt >= act.hws) && (hcnt < act.hbe);
  assign in_wv = (vcnt >= vws) && (vcnt < act.vbe);
  assign show  = act.vid && in_bh && in_bv;
  assign dx    = hcnt - act.hws;

  assign win_act    = show && in_wh && in_wv && act.disp && !act.blank;
  assign border_act = show && !win_act;
  assign hsync      = act.vid && (hcnt < act.hbs);
  assign vsync      = act.vid && (vcnt < act.vbs);
  assign pix_x      = win_act ? (act.pixdbl ? (dx >> 1) : dx) : '0;
  assign line_y     = win_act ? (vcnt - vws) : '0;
  assign field      = fld;
  assign pix_ce     = ce_q;
  assign border_rgb = act.rgb;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wrap,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] vcnt,
  input logic [CW-1:0] htot,
  input logic [CW-1:0] vtot,
  input logic          fast,
  input logic          blank,
  input logic          vid,
  input logic          fld,
  input logic          ce,
  input logic          hsync,
  input logic          vsync,
  input logic          win_act
);

  p_hcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n) hcnt <= htot);
  p_vcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) vcnt <= vtot);
  p_wrap_zero_r6:  assert property (@(posedge clk) disable iff (!rst_n) wrap |=> (hcnt == '0 && vcnt == '0));
  p_cfg_hold_r6:   assert property (@(posedge clk) disable iff (!rst_n) !wrap |=> ($stable(htot) && $stable(vtot)));
  p_blank_r7:      assert property (@(posedge clk) disable iff (!rst_n) blank |-> !win_act);
  p_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !wrap |=> $stable(fld));
  p_ce_fast_r11:   assert property (@(posedge clk) disable iff (!rst_n) (fast && !wrap) |=> ce);
  p_sync_off_r12:  assert property (@(posedge clk) disable iff (!rst_n) !vid |-> (!hsync && !vsync && !win_act));

endmodule

bind raster_timing raster_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .hcnt(hcnt), .vcnt(vcnt),
  .htot(act.htot), .vtot(act.vtot), .fast(act.fast), .blank(act.blank),
  .vid(act.vid), .fld(fld), .ce(ce_q), .hsync(hsync), .vsync(vsync),
  .win_act(win_act)
);

// File: tb/sim_raster_timing.sv
module sim_raster_timing;
  localparam int CW = 12;
  localparam int CLRW = 24;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync, vsync, border_act, win_act, field, pix_ce;
  logic [CW-1:0] pix_x, line_y;
  logic [CLRW-1:0] border_rgb;

  raster_timing u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .border_act(border_act), .win_act(win_act), .field(field),
    .pix_ce(pix_ce), .pix_x(pix_x), .line_y(line_y), .border_rgb(border_rgb));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int eh, ev, ehbs, ehbe, evbs, evbe, ehws, evws0, evws1;
  bit eblank, epix, edscan, efast, edisp, evid, eil;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_all();
    wr(0, {16'(ev), 16'(eh)});
    wr(1, {16'(ehbs), 16'(ehbe)});
    wr(2, {16'(evbs), 16'(evbe)});
    wr(3, 32'(ehws));
    wr(4, {16'(evws1), 16'(evws0)});
    wr(5, 32'h0012_3456);
    wr(6, {28'h0, eblank, 2'b00, epix});
    wr(7, {8'h0, efast, 21'h0, edscan, edisp});
    wr(8, {23'h0, evid, 3'h0, eil, 4'h0});
  endtask

  task automatic wait_field();
    while (vsync !== 1'b0) @(negedge clk);
    while (vsync !== 1'b1) @(negedge clk);
  endtask

  task automatic apply();
    wait_field();
    program_all();
    wait_field();
  endtask

  task automatic base_cfg();
    eh = 19; ev = 11; ehbs = 4; ehbe = 18; evbs = 2; evbe = 10; ehws = 6; evws0 = 3; evws1 = 4;
    eblank = 0; epix = 0; edscan = 0; efast = 1; edisp = 1; evid = 1; eil = 0;
  endtask

  task automatic scan(string tag, int n, bit first_field);
    int mh = 0, mv = 0;
    bit mrep = 0, mf = first_field;
    for (int t = 0; t < n; t++) begin
      int vws;
      bit inb, win, ece;
      logic [CW-1:0] ex, ey;
      vws = mf ? evws1 : evws0;
      ece = efast ? 1'b1 : t[0];
      inb = evid && mh >= ehbs && mh < ehbe && mv >= evbs && mv < evbe;
      win = inb && mh >= ehws && mv >= vws && edisp && !eblank;
      ex = win ? CW'((mh - ehws) >> epix) : '0;
      ey = win ? CW'(mv - vws) : '0;
      check(tag, {34'h0, hsync, vsync, border_act, win_act, field, pix_ce, pix_x, line_y},
            {34'h0, evid && (mh < ehbs), evid && (mv < evbs), inb && !win, win, mf, ece, ex, ey});
      if (ece) begin
        if (mh == eh) begin
          mh = 0;
          if (edscan && !mrep) mrep = 1;
          else begin
            mrep = 0;
            if (mv == ev) begin mv = 0; mf = eil ? ~mf : 1'b0; end
            else mv++;
          end
        end else mh++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset outputs", {58'h0, hsync, vsync, field, win_act, border_act, pix_ce},
          {58'h0, 6'b110001});
  endtask

  task automatic t_basic();
    base_cfg();
    apply();
    check("R4 border colour", 64'(border_rgb), 64'h12_3456);
    scan("R2 R3 R4 R5 basic field", 2 * 240, 1'b0);
  endtask

  task automatic t_shadow();
    int n = 0;
    bit prev = 1'b1;
    base_cfg();
    wait_field();
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = {16'd11, 16'd29};
    forever begin
      @(negedge clk);
      wr_en = 1'b0;
      n++;
      if (!prev && vsync) break;
      prev = vsync;
    end
    check("R6 old period kept", 64'(n), 64'd240);
    n = 0; prev = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (!prev && vsync) break;
      prev = vsync;
    end
    check("R6 new period after wrap", 64'(n), 64'd360);
    eh = 29;
    scan("R6 new timing", 360, 1'b0);
    base_cfg();
    apply();
  endtask

  task automatic t_blank();
    base_cfg(); eblank = 1; apply();
    scan("R7 blank", 240, 1'b0);
    base_cfg(); apply();
    scan("R7 unblank", 240, 1'b0);
  endtask

  task automatic t_ilace();
    base_cfg(); eil = 1; apply();
    scan("R8 interlace fields", 3 * 240, 1'b1);
    base_cfg(); apply();
    scan("R8 interlace off", 240, 1'b0);
  endtask

  task automatic t_dscan();
    base_cfg(); edscan = 1; apply();
    scan("R9 doublescan", 2 * 480, 1'b0);
  endtask

  task automatic t_pixdbl();
    base_cfg(); epix = 1; apply();
    scan("R10 pixel doubling", 240, 1'b0);
  endtask

  task automatic t_slow();
    base_cfg(); efast = 0; apply();
    scan("R11 half rate clock", 2 * 480, 1'b0);
    base_cfg(); apply();
    scan("R11 full rate clock", 240, 1'b0);
  endtask

  task automatic t_enables();
    base_cfg(); edisp = 0; apply();
    scan("R12 display disabled", 240, 1'b0);
    base_cfg(); evid = 0;
    wait_field();
    program_all();
    repeat (300) @(negedge clk);
    for (int i = 0; i < 240; i++) begin
      check("R12 video disabled", {60'h0, hsync, vsync, border_act, win_act}, 64'h0);
      @(negedge clk);
    end
    base_cfg();
    program_all();
    wait_field();
    scan("R12 video re-enabled", 240, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_shadow();
    t_blank();
    t_ilace();
    t_dscan();
    t_pixdbl();
    t_slow();
    t_enables();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule